// File: doc/BRIEF.md
# Multiprocessor Serial Receive Controller

This block is the receive half of a classic microcontroller serial port. It turns a serial RX line into bytes in one of four modes. Mode 00 is a clocked shift mode that takes eight bits on an external shift strobe. Mode 01 is an 8-bit asynchronous frame. Modes 10 and 11 are 9-bit asynchronous frames; they behave the same here because the bit rate is supplied from outside. In the asynchronous modes the line is oversampled, one step per `bit_tick`. A start is accepted only if a majority vote at mid-bit confirms it. Each data bit and the stop bit are then taken by the same mid-bit vote.

Software drives one 8-bit control/status register through a write strobe and a flag-clear mask. The receive flag doubles as the interrupt output. In the 9-bit modes a node can enable address filtering: only frames whose ninth bit is 1 raise the flag. Once the node sees its own address it drops the filter and takes the data frames that follow. A stop bit sampled low sets a sticky framing-error flag. That flag shares the top register bit with a mode bit, and the external `fe_sel` input chooses which of the two the top bit reads and writes.

Top module: `mprx_top`

## Requirements
- R1: After reset, the control register reads 0x00, `rx_data` is 0x00 and `rx_irq` is low. Register layout: bit7 = mode-high bit or framing-error flag, bit6 = mode-low bit, bit5 = address-filter enable, bit4 = receive enable, bit2 = received ninth bit, bit0 = receive flag. Bits 3 and 1 read 0. The mode is {bit7-as-mode, bit6}.
- R2: In mode 01 a frame is a low start bit, 8 data bits LSB first, then a stop bit. The byte goes to `rx_data`, the stop bit goes to bit2, and bit0 (`rx_irq`) is set.
- R3: In modes 10 and 11 a frame has 9 data bits, LSB first. The low eight go to `rx_data` and the ninth goes to bit2.
- R4: A falling edge whose majority vote over oversample steps 7, 8 and 9 reads high is dropped. The receiver returns to idle and still takes the next good frame.
- R5: A stop bit sampled as 0 in any asynchronous mode sets the framing-error flag, even if the frame itself is discarded. The flag stays set through later good frames until software clears or writes it.
- R6: With `fe_sel`=1, bit7 reads and writes the framing-error flag. With `fe_sel`=0, bit7 reads and writes the mode-high bit. Each storage keeps its value while the other one is selected.
- R7: In modes 10 and 11 with the filter enabled, a frame whose ninth bit is 0 leaves the flag, `rx_data` and bit2 untouched. A frame whose ninth bit is 1 is accepted. Once the filter is cleared, frames with a ninth bit of 0 are accepted.
- R8: In mode 01 with the filter enabled, a frame whose stop bit is 0 does not raise the flag.
- R9: In mode 00, with receive enabled and the flag clear, eight bits are sampled LSB first, one on each `shift_tick`, and then the flag is set. The filter enable has no effect in this mode.
- R10: While the flag is set, a newly received frame does not change `rx_data` or bit2.
- R11: With receive enable clear, line activity changes neither `rx_data` nor the flags.
- R12: A 1 in `ctl_clr` bit0, bit2 or bit7 clears the receive flag, the ninth-bit flag or the framing-error flag respectively. The framing-error flag is cleared this way only while `fe_sel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Oversample step enable for the asynchronous modes |
| shift_tick | input | 1 | Bit strobe for shift mode |
| rx | input | 1 | Serial receive line, idle high |
| fe_sel | input | 1 | Selects framing-error flag (1) or mode-high bit (0) at bit7 |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_clr | input | 8 | Flag clear mask, one cycle |
| ctl_rdata | output | 8 | Control register read value |
| rx_data | output | DATA_W | Last accepted received byte |
| rx_irq | output | 1 | Receive flag / interrupt |

## Verification
The bench uses the default parameters: 16 oversample steps per bit, an 8-bit data path and a two-stage input synchronizer. It raises `bit_tick` on every second clock, so each serial bit lasts 32 clocks. Over that span a start glitch of three steps falls wholly before the voting window. The synchronizer delay also stays well inside one step. Together these make the mid-bit sampling, the short-start rejection and the stop-bit sampling of every mode observable at the ports.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_ASYNC8 = 2'b01,
    MODE_NINE_A = 2'b10,
    MODE_NINE_B = 2'b11
  } mprx_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_SHIFT
  } mprx_state_e;

  // control register bit positions (software-visible layout)
  localparam int unsigned CB_TOP  = 7;
  localparam int unsigned CB_LOW  = 6;
  localparam int unsigned CB_MPEN = 5;
  localparam int unsigned CB_REN  = 4;
  localparam int unsigned CB_B9   = 2;
  localparam int unsigned CB_RI   = 0;

endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mprx_sampler.sv
module mprx_sampler #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic active,
  input  logic rxs,
  output logic vote_stb,
  output logic vote
);

  localparam int unsigned CW  = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned MID = OVS / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          s_a_q, s_a_d;
  logic          s_b_q, s_b_d;

  always_comb begin
    cnt_d = cnt_q;
    s_a_d = s_a_q;
    s_b_d = s_b_q;
    if (restart) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == CW'(OVS - 1)) ? '0 : cnt_q + CW'(1);
      if (cnt_q == CW'(MID - 1)) s_a_d = rxs;
      if (cnt_q == CW'(MID))     s_b_d = rxs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      s_a_q <= 1'b1;
      s_b_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      s_a_q <= s_a_d;
      s_b_q <= s_b_d;
    end
  end

  assign vote_stb = active & tick & ~restart & (cnt_q == CW'(MID + 1));
  assign vote     = (s_a_q & s_b_q) | (s_a_q & rxs) | (s_b_q & rxs);

endmodule

// File: rtl/mprx_frame.sv
module mprx_frame
  import mprx_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              shift_tick,
  input  logic              rxs,
  input  logic              ren,
  input  logic              ri,
  input  mprx_mode_e        mode,
  output logic              done,
  output logic [DATA_W:0]   frame_bits,
  output logic              stop_bit
);

  localparam int unsigned NB = DATA_W + 1;
  localparam int unsigned IW = $clog2(NB + 1);

  mprx_state_e     state_q, state_d;
  logic [IW-1:0]   idx_q, idx_d;
  logic [NB-1:0]   sh_q, sh_d;
  logic            prev_q, prev_d;
  logic            is_async, is_nine;
  logic [IW-1:0]   last_idx;
  logic            start_det;
  logic            smp_active;
  logic            vote_stb, vote;

  assign is_async   = (mode != MODE_SHIFT);
  assign is_nine    = (mode == MODE_NINE_A) || (mode == MODE_NINE_B);
  assign last_idx   = is_nine ? IW'(DATA_W) : IW'(DATA_W - 1);
  assign start_det  = (state_q == ST_IDLE) & ren & is_async & tick & ~rxs & prev_q;
  assign smp_active = (state_q == ST_START) || (state_q == ST_DATA) || (state_q == ST_STOP);

  mprx_sampler #(.OVS(OVS)) u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .restart  (start_det),
    .active   (smp_active),
    .rxs      (rxs),
    .vote_stb (vote_stb),
    .vote     (vote)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    prev_d   = tick ? rxs : prev_q;
    done     = 1'b0;
    stop_bit = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (ren) begin
          if (!is_async) begin
            if (!ri) begin
              state_d = ST_SHIFT;
              idx_d   = '0;
            end
          end else if (start_det) begin
            state_d = ST_START;
          end
        end
      end
      ST_START: begin
        if (!ren) begin
          state_d = ST_IDLE;
        end else if (vote_stb) begin
          if (vote) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_DATA;
            idx_d   = '0;
          end
        end
      end
      ST_DATA: begin
        if (!ren) begin
          state_d = ST_IDLE;
        end else if (vote_stb) begin
          sh_d[idx_q] = vote;
          if (idx_q == last_idx) state_d = ST_STOP;
          else                   idx_d   = idx_q + IW'(1);
        end
      end
      ST_STOP: begin
        if (!ren) begin
          state_d = ST_IDLE;
        end else if (vote_stb) begin
          done     = 1'b1;
          stop_bit = vote;
          state_d  = ST_IDLE;
        end
      end
      ST_SHIFT: begin
        if (!ren || is_async) begin
          state_d = ST_IDLE;
        end else if (shift_tick) begin
          sh_d[idx_q] = rxs;
          if (idx_q == IW'(DATA_W - 1)) begin
            done    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            idx_d = idx_q + IW'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      prev_q  <= prev_d;
    end
  end

  assign frame_bits = sh_d;

endmodule

// File: rtl/mprx_regs.sv
module mprx_regs
  import mprx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic [7:0]        ctl_clr,
  input  logic              fe_sel,
  input  logic              done,
  input  logic [DATA_W:0]   frame_bits,
  input  logic              stop_bit,
  output mprx_mode_e        mode,
  output logic              mpen,
  output logic              ren,
  output logic              ri,
  output logic              fe_flag,
  output logic [7:0]        ctl_rdata,
  output logic [DATA_W-1:0] rx_data
);

  logic              sm_hi_q, sm_hi_d;
  logic              sm_lo_q, sm_lo_d;
  logic              mpen_q,  mpen_d;
  logic              ren_q,   ren_d;
  logic              b9_q,    b9_d;
  logic              ri_q,    ri_d;
  logic              fe_q,    fe_d;
  logic [DATA_W-1:0] dat_q,   dat_d;
  logic              qualify, accept, is_async;
  logic              unused_ok;

  assign mode     = mprx_mode_e'({sm_hi_q, sm_lo_q});
  assign is_async = (mode != MODE_SHIFT);

  always_comb begin
    case (mode)
      MODE_SHIFT:  qualify = 1'b1;
      MODE_ASYNC8: qualify = ~mpen_q | stop_bit;
      default:     qualify = ~mpen_q | frame_bits[DATA_W];
    endcase
    accept = done & ~ri_q & qualify;
  end

  always_comb begin
    sm_hi_d = sm_hi_q;
    sm_lo_d = sm_lo_q;
    mpen_d  = mpen_q;
    ren_d   = ren_q;
    b9_d    = b9_q;
    ri_d    = ri_q;
    fe_d    = fe_q;
    dat_d   = dat_q;
    // software write
    if (ctl_wr) begin
      if (fe_sel) fe_d    = ctl_wdata[CB_TOP];
      else        sm_hi_d = ctl_wdata[CB_TOP];
      sm_lo_d = ctl_wdata[CB_LOW];
      mpen_d  = ctl_wdata[CB_MPEN];
      ren_d   = ctl_wdata[CB_REN];
      b9_d    = ctl_wdata[CB_B9];
      ri_d    = ctl_wdata[CB_RI];
    end
    // software clear mask
    if (ctl_clr[CB_TOP] && fe_sel) fe_d = 1'b0;
    if (ctl_clr[CB_B9])            b9_d = 1'b0;
    if (ctl_clr[CB_RI])            ri_d = 1'b0;
    // hardware events take precedence over software in the same cycle
    if (done && is_async && !stop_bit) fe_d = 1'b1;
    if (accept) begin
      dat_d = frame_bits[DATA_W-1:0];
      ri_d  = 1'b1;
      if (mode == MODE_ASYNC8)  b9_d = stop_bit;
      else if (is_async)        b9_d = frame_bits[DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sm_hi_q <= 1'b0;
      sm_lo_q <= 1'b0;
      mpen_q  <= 1'b0;
      ren_q   <= 1'b0;
      b9_q    <= 1'b0;
      ri_q    <= 1'b0;
      fe_q    <= 1'b0;
      dat_q   <= '0;
    end else begin
      sm_hi_q <= sm_hi_d;
      sm_lo_q <= sm_lo_d;
      mpen_q  <= mpen_d;
      ren_q   <= ren_d;
      b9_q    <= b9_d;
      ri_q    <= ri_d;
      fe_q    <= fe_d;
      dat_q   <= dat_d;
    end
  end

  always_comb begin
    ctl_rdata          = '0;
    ctl_rdata[CB_TOP]  = fe_sel ? fe_q : sm_hi_q;
    ctl_rdata[CB_LOW]  = sm_lo_q;
    ctl_rdata[CB_MPEN] = mpen_q;
    ctl_rdata[CB_REN]  = ren_q;
    ctl_rdata[CB_B9]   = b9_q;
    ctl_rdata[CB_RI]   = ri_q;
  end

  assign unused_ok = ^{ctl_wdata[3], ctl_wdata[1], ctl_clr[6:3], ctl_clr[1]};

  assign mpen    = mpen_q;
  assign ren     = ren_q;
  assign ri      = ri_q;
  assign fe_flag = fe_q;
  assign rx_data = dat_q;

endmodule

// File: rtl/mprx_top.sv
module mprx_top
  import mprx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              shift_tick,
  input  logic              rx,
  input  logic              fe_sel,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic [7:0]        ctl_clr,
  output logic [7:0]        ctl_rdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_irq
);

  logic              rst_core_n;
  logic              rx_s;
  logic              frm_done;
  logic [DATA_W:0]   frm_bits;
  logic              frm_stop;
  mprx_mode_e        mode_q;
  logic              mpen_q, ren_q, ri_q, fe_q;

  // reset: asserted asynchronously, released on a clock edge
  mprx_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  mprx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (rx),
    .q     (rx_s)
  );

  mprx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .tick       (bit_tick),
    .shift_tick (shift_tick),
    .rxs        (rx_s),
    .ren        (ren_q),
    .ri         (ri_q),
    .mode       (mode_q),
    .done       (frm_done),
    .frame_bits (frm_bits),
    .stop_bit   (frm_stop)
  );

  mprx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ctl_clr    (ctl_clr),
    .fe_sel     (fe_sel),
    .done       (frm_done),
    .frame_bits (frm_bits),
    .stop_bit   (frm_stop),
    .mode       (mode_q),
    .mpen       (mpen_q),
    .ren        (ren_q),
    .ri         (ri_q),
    .fe_flag    (fe_q),
    .ctl_rdata  (ctl_rdata),
    .rx_data    (rx_data)
  );

  assign rx_irq = ri_q;

endmodule

// File: rtl/mprx_chk.sv
module mprx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic [7:0]        ctl_wdata,
  input logic [7:0]        ctl_clr,
  input logic              fe_sel,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_irq,
  input logic              frm_done,
  input logic              frm_b9,
  input logic              frm_stop,
  input logic [1:0]        mode_bits,
  input logic              mp_en,
  input logic              fe_flag
);

  // R2: the receive flag rises only from a finished frame or a software write
  assert_irq_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> ($past(frm_done) || $past(ctl_wr && ctl_wdata[0])));

  // R10: a pending flag protects the received byte
  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> $stable(rx_data));

  // R5: framing error flag is sticky until software touches it
  assert_fe_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_flag && !(fe_sel && ((ctl_wr && !ctl_wdata[7]) || ctl_clr[7]))) |=> fe_flag);

  // R5: a low stop bit in an asynchronous mode sets the flag
  assert_fe_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && (mode_bits != 2'b00) && !frm_stop) |=> fe_flag);

  // R7: data frames are filtered in the 9-bit modes
  assert_addr_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && mode_bits[1] && mp_en && !frm_b9 && !rx_irq && !ctl_wr) |=> !rx_irq);

  // R8: a bad stop bit is filtered in the 8-bit mode
  assert_stop_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && (mode_bits == 2'b01) && mp_en && !frm_stop && !rx_irq && !ctl_wr) |=> !rx_irq);

  // R9: shift mode ignores the filter enable
  assert_shift_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && (mode_bits == 2'b00) && !rx_irq) |=> rx_irq);

endmodule

bind mprx_top mprx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .ctl_wdata (ctl_wdata),
  .ctl_clr   (ctl_clr),
  .fe_sel    (fe_sel),
  .rx_data   (rx_data),
  .rx_irq    (rx_irq),
  .frm_done  (frm_done),
  .frm_b9    (frm_bits[DATA_W]),
  .frm_stop  (frm_stop),
  .mode_bits (mode_q),
  .mp_en     (mpen_q),
  .fe_flag   (fe_q)
);

// File: tb/tb_mprx_top.sv
`timescale 1ns/1ps
module tb_mprx_top;

  localparam int OVS  = 16;
  localparam int DW   = 8;
  localparam int TDIV = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_tick = 1'b0;
  logic          shift_tick = 1'b0;
  logic          rx = 1'b1;
  logic          fe_sel = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic [7:0]    ctl_clr = '0;
  logic [7:0]    ctl_rdata;
  logic [DW-1:0] rx_data;
  logic          rx_irq;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          over   = 1'b0;
  int          tcnt   = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (tcnt == TDIV - 1) begin tcnt <= 0; bit_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; bit_tick <= 1'b0; end
  end

  mprx_top #(.OVS(OVS), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .shift_tick(shift_tick),
    .rx(rx), .fe_sel(fe_sel), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_clr(ctl_clr), .ctl_rdata(ctl_rdata), .rx_data(rx_data), .rx_irq(rx_irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (bit_tick) k++;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr(input logic [7:0] m);
    @(negedge clk); ctl_clr = m;
    @(negedge clk); ctl_clr = '0;
    @(negedge clk);
  endtask

  task automatic send_async(input int nb, input logic [8:0] d, input logic stopv);
    rx = 1'b0; wait_ticks(OVS);
    for (int i = 0; i < nb; i++) begin rx = d[i]; wait_ticks(OVS); end
    rx = stopv; wait_ticks(OVS);
    rx = 1'b1; wait_ticks(2 * OVS);
  endtask

  task automatic send_shift(input logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (4) @(negedge clk);
      shift_tick = 1'b1;
      @(negedge clk);
      shift_tick = 1'b0;
    end
    repeat (4) @(negedge clk);
    rx = 1'b1;
  endtask

  function automatic logic exp_accept(input logic [1:0] m, input logic mp,
                                      input logic b9, input logic sb);
    if (m == 2'b00) return 1'b1;
    if (m == 2'b01) return !mp || sb;
    return !mp || b9;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!over) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] last;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check("R1 rdata", ctl_rdata, 8'h00);
    check("R1 rx_data", rx_data, 8'h00);
    check("R1 irq", rx_irq, 1'b0);

    // R11 receive disabled
    wr(8'h40);
    send_async(8, 9'h0A5, 1'b1);
    check("R11 irq", rx_irq, 1'b0);
    check("R11 rx_data", rx_data, 8'h00);
    check("R11 rdata", ctl_rdata, 8'h40);

    // R2 8-bit frame
    wr(8'h50);
    send_async(8, 9'h03C, 1'b1);
    check("R2 rx_data", rx_data, 8'h3C);
    check("R2 irq", rx_irq, 1'b1);
    check("R2 rdata", ctl_rdata, 8'h55);

    // R12 clear mask
    clr(8'h01);
    check("R12 ri clear", ctl_rdata, 8'h54);
    check("R12 irq low", rx_irq, 1'b0);
    clr(8'h04);
    check("R12 b9 clear", ctl_rdata, 8'h50);

    // R10 no overwrite while flag pending
    send_async(8, 9'h011, 1'b1);
    check("R10 first", rx_data, 8'h11);
    send_async(8, 9'h022, 1'b1);
    check("R10 kept", rx_data, 8'h11);
    check("R10 rdata", ctl_rdata, 8'h55);
    clr(8'h05);

    // R4 short start rejected
    rx = 1'b0; wait_ticks(3); rx = 1'b1; wait_ticks(3 * OVS);
    check("R4 glitch irq", rx_irq, 1'b0);
    check("R4 glitch rdata", ctl_rdata, 8'h50);
    send_async(8, 9'h05A, 1'b1);
    check("R4 recover", rx_data, 8'h5A);
    clr(8'h05);

    // R5 framing error, sticky
    fe_sel = 1'b1;
    @(negedge clk);
    check("R5 fe clear", ctl_rdata, 8'h50);
    send_async(8, 9'h077, 1'b0);
    check("R5 fe set", ctl_rdata, 8'hD1);
    check("R5 data", rx_data, 8'h77);
    clr(8'h01);
    send_async(8, 9'h066, 1'b1);
    check("R5 sticky", ctl_rdata, 8'hD5);
    clr(8'h05);

    // R6 shared top bit
    fe_sel = 1'b0;
    @(negedge clk);
    check("R6 mode view", ctl_rdata, 8'h50);
    send_async(8, 9'h099, 1'b1);
    check("R6 mode kept", rx_data, 8'h99);
    clr(8'h05);
    fe_sel = 1'b1;
    clr(8'h80);
    check("R12 fe clear", ctl_rdata, 8'h50);
    wr(8'hD0);
    check("R6 fe written", ctl_rdata, 8'hD0);
    fe_sel = 1'b0;
    @(negedge clk);
    check("R6 mode untouched", ctl_rdata, 8'h50);
    fe_sel = 1'b1;
    clr(8'h80);
    fe_sel = 1'b0;
    wr(8'hD0);
    check("R6 mode written", ctl_rdata, 8'hD0);
    fe_sel = 1'b1;
    @(negedge clk);
    check("R6 fe untouched", ctl_rdata, 8'h50);
    fe_sel = 1'b0;
    @(negedge clk);

    // R3 9-bit frames
    send_async(9, 9'h1B4, 1'b1);
    check("R3 data", rx_data, 8'hB4);
    check("R3 b9 one", ctl_rdata, 8'hD5);
    clr(8'h05);
    send_async(9, 9'h04B, 1'b1);
    check("R3 data2", rx_data, 8'h4B);
    check("R3 b9 zero", ctl_rdata, 8'hD1);
    wr(8'h90);
    send_async(9, 9'h1E1, 1'b1);
    check("R3 mode10", rx_data, 8'hE1);
    check("R3 mode10 b9", ctl_rdata, 8'h95);

    // R7 address filtering
    wr(8'hB0);
    send_async(9, 9'h0C3, 1'b1);
    check("R7 data frame irq", rx_irq, 1'b0);
    check("R7 data frame kept", rx_data, 8'hE1);
    send_async(9, 9'h12A, 1'b1);
    check("R7 address", rx_data, 8'h2A);
    check("R7 address rdata", ctl_rdata, 8'hB5);
    wr(8'h90);
    send_async(9, 9'h055, 1'b1);
    check("R7 after addr", rx_data, 8'h55);
    check("R7 after addr irq", rx_irq, 1'b1);

    // R8 stop check in 8-bit mode
    wr(8'h70);
    send_async(8, 9'h033, 1'b0);
    check("R8 bad stop irq", rx_irq, 1'b0);
    check("R8 bad stop data", rx_data, 8'h55);
    send_async(8, 9'h044, 1'b1);
    check("R8 good stop", rx_data, 8'h44);
    check("R8 rdata", ctl_rdata, 8'h75);

    // R9 shift mode, filter enable ignored
    wr(8'h30);
    send_shift(8'hC6);
    check("R9 data", rx_data, 8'hC6);
    check("R9 rdata", ctl_rdata, 8'h31);
    wr(8'h10);
    send_shift(8'h3A);
    check("R9 data2", rx_data, 8'h3A);
    check("R9 irq", rx_irq, 1'b1);

    // random frames across asynchronous modes (R2 R3 R7 R8 R10)
    last = rx_data;
    for (int i = 0; i < 24; i++) begin
      logic [1:0] m;
      logic       mp, sb, acc;
      logic [8:0] d;
      m   = 2'd1 + 2'($urandom_range(0, 2));
      mp  = 1'($urandom_range(0, 1));
      d   = 9'($urandom);
      sb  = ($urandom_range(0, 3) != 0);
      wr({m, mp, 1'b1, 4'b0000});
      send_async((m == 2'b01) ? 8 : 9, d, sb);
      acc = exp_accept(m, mp, d[8], sb);
      if (acc) last = d[7:0];
      check("R7 R8 random irq", rx_irq, acc);
      check("R2 R3 random data", rx_data, last);
      if (acc) check("R3 random b9", ctl_rdata[2], (m == 2'b01) ? sb : d[8]);
    end

    over = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule